// File: doc/BRIEF.md
# GPIO Edge Interrupt Status Unit

This unit watches a set of already-debounced GPIO input pins, finds their transitions, and records each transition in one of two sticky status banks. A per-pin polarity bit selects which edge is the *assert* event. The opposite edge is the *deassert* event. Assert events go into the assert bank and deassert events go into the deassert bank. Each bank has its own interrupt output. A per-pin enable bit decides whether a latched event contributes to that output. Status bits latch whether or not the pin is enabled.

Software reaches the unit through a single-cycle register write port and a combinational read port. The address carries a 2-bit register kind and a 3-bit register index:

- Kind 0 is polarity.
- Kind 1 is enable.
- Kind 2 is assert status.
- Kind 3 is deassert status.

Polarity and enable registers hold 32 pins each. Status registers hold 31 pins each in bits 31:1, and bit 0 of a written word chooses between setting and clearing the bits written as 1. The set mode lets software inject events for testing.

Both-edge detection uses polarity 1 and watches both interrupt outputs.

Top module: `gpio_evt_top`

## Requirements
- R1: While reset is held, and directly after it, all polarity, enable and status bits read 0 and both interrupt outputs are low.
- R2: With a pin's polarity bit at 1, a rising input latches that pin's bit in the assert bank and a falling input latches it in the deassert bank.
- R3: With a pin's polarity bit at 0, a falling input latches the assert bank and a rising input latches the deassert bank.
- R4: In status registers (kinds 2 and 3), pin n appears at index n/31, bit (n mod 31)+1. Bit 0 and bits of nonexistent pins always read 0.
- R5: In polarity and enable registers (kinds 0 and 1), pin n appears at index n/32, bit n mod 32. A write stores the bits of existing pins, and reading back returns them. Bits of nonexistent pins read 0.
- R6: A status write with bit 0 = 0 clears each status bit written as 1 and leaves the bits written as 0 unchanged.
- R7: A status write with bit 0 = 1 sets each status bit written as 1 and leaves the bits written as 0 unchanged.
- R8: Status bits latch regardless of enable. Each interrupt output is high exactly when some pin has both its status bit in that bank and its enable bit set. The output stays high until that condition is removed by software.
- R9: If an event on a pin arrives in the same cycle as a clearing write to that pin's bit, the bit ends up set.
- R10: An input change applied between clock edges is visible in status after the third following rising clock edge, and not after the second. This delay comes from two synchroniser flops plus the previous-sample compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinsIn | input | NUM_PINS | Debounced GPIO input levels |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write address: kind in bits 4:3, index in bits 2:0 |
| wrData | input | 32 | Write data |
| rdAddr | input | 5 | Read address, same layout as wrAddr |
| rdData | output | 32 | Combinational read data |
| irqAssert | output | 1 | Interrupt from the assert bank |
| irqDeassert | output | 1 | Interrupt from the deassert bank |

## Verification
The bound checker examines, on every cycle:

- the quiet state under reset;
- that an assert or deassert event for pin 0 always latches, including against a concurrent clear;
- the set and clear write modes on pin 0;
- that the two events of one pin are never both raised at once;
- that the assert interrupt does not drop without a write;
- that bit 0 of a status read is zero.

Only the bench's scenarios can show the following, by comparing every register against a reference model after random pin toggles, configuration writes and status writes:

- the pin-to-bit mapping across register boundaries;
- the effect of polarity choices on the wider pin set;
- the exact three-edge detection latency;
- the OR-with-enable behaviour of the interrupt outputs.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  localparam int REG_IDX_W = 3;
  localparam int KIND_W    = 2;
  localparam int ADDR_W    = KIND_W + REG_IDX_W;
  localparam int REG_W     = 32;
  localparam int CFG_PER   = 32;
  localparam int STS_PER   = 31;

  typedef enum logic [KIND_W-1:0] {
    KIND_POL    = 2'd0,
    KIND_EN     = 2'd1,
    KIND_STS_AS = 2'd2,
    KIND_STS_DE = 2'd3
  } regKind_e;

  typedef struct packed {
    logic                 polWe;
    logic                 enWe;
    logic                 stsAsWe;
    logic                 stsDeWe;
    logic [REG_IDX_W-1:0] idx;
    logic [REG_W-1:0]     data;
    regKind_e             rdKind;
    logic [REG_IDX_W-1:0] rdIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinsIn,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  logic [WIDTH-1:0] syncA;
  logic [WIDTH-1:0] syncB;
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevQ <= '0;
    end else begin
      syncA <= pinsIn;
      syncB <= syncA;
      prevQ <= syncB;
    end
  end

  assign rise = syncB & ~prevQ;
  assign fall = ~syncB & prevQ;

endmodule

// File: rtl/gpio_evt_ctrl.sv
module gpio_evt_ctrl
  import gpio_evt_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrobe_t       strobe
);

  regKind_e wrKind;

  assign wrKind = regKind_e'(wrAddr[ADDR_W-1 -: KIND_W]);

  always_comb begin
    strobe         = '0;
    strobe.polWe   = wrEn && (wrKind == KIND_POL);
    strobe.enWe    = wrEn && (wrKind == KIND_EN);
    strobe.stsAsWe = wrEn && (wrKind == KIND_STS_AS);
    strobe.stsDeWe = wrEn && (wrKind == KIND_STS_DE);
    strobe.idx     = wrAddr[REG_IDX_W-1:0];
    strobe.data    = wrData;
    strobe.rdKind  = regKind_e'(rdAddr[ADDR_W-1 -: KIND_W]);
    strobe.rdIdx   = rdAddr[REG_IDX_W-1:0];
  end

endmodule

// File: rtl/gpio_evt_datapath.sv
module gpio_evt_datapath
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 40
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PINS-1:0]           pinsIn,
  input  ctrlStrobe_t                   strobe,
  output logic [REG_W-1:0]              rdData,
  output logic                          irqAssert,
  output logic                          irqDeassert,
  output logic [NUM_PINS-1:0]           evtAs,
  output logic [NUM_PINS-1:0]           evtDe,
  output logic [((NUM_PINS+STS_PER-1)/STS_PER)*REG_W-1:0] stsAsFlat,
  output logic [((NUM_PINS+STS_PER-1)/STS_PER)*REG_W-1:0] stsDeFlat
);

  localparam int CFG_REGS = (NUM_PINS + CFG_PER - 1) / CFG_PER;
  localparam int STS_REGS = (NUM_PINS + STS_PER - 1) / STS_PER;

  logic [NUM_PINS-1:0] polQ, enQ, stsAsQ, stsDeQ;
  logic [NUM_PINS-1:0] polNext, enNext, stsAsNext, stsDeNext;
  logic [NUM_PINS-1:0] rise, fall;
  logic [CFG_REGS*REG_W-1:0] polFlat, enFlat;

  gpio_evt_edge #(.WIDTH(NUM_PINS)) uEdge (
    .clk   (clk),
    .rstN  (rstN),
    .pinsIn(pinsIn),
    .rise  (rise),
    .fall  (fall)
  );

  assign evtAs = (rise & polQ) | (fall & ~polQ);
  assign evtDe = (fall & polQ) | (rise & ~polQ);

  for (genvar p = 0; p < NUM_PINS; p++) begin : gPin
    localparam int CR = p / CFG_PER;
    localparam int CB = p % CFG_PER;
    localparam int SR = p / STS_PER;
    localparam int SB = (p % STS_PER) + 1;

    logic cfgSel, stsSel, asHit, deHit;

    assign cfgSel = (int'(strobe.idx) == CR);
    assign stsSel = (int'(strobe.idx) == SR);
    assign asHit  = strobe.stsAsWe && stsSel && strobe.data[SB];
    assign deHit  = strobe.stsDeWe && stsSel && strobe.data[SB];

    assign polNext[p] = (strobe.polWe && cfgSel) ? strobe.data[CB] : polQ[p];
    assign enNext[p]  = (strobe.enWe && cfgSel) ? strobe.data[CB] : enQ[p];
    // a fresh event always wins over a concurrent clear
    assign stsAsNext[p] = evtAs[p] | (asHit ? strobe.data[0] : stsAsQ[p]);
    assign stsDeNext[p] = evtDe[p] | (deHit ? strobe.data[0] : stsDeQ[p]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ   <= '0;
      enQ    <= '0;
      stsAsQ <= '0;
      stsDeQ <= '0;
    end else begin
      polQ   <= polNext;
      enQ    <= enNext;
      stsAsQ <= stsAsNext;
      stsDeQ <= stsDeNext;
    end
  end

  for (genvar r = 0; r < STS_REGS; r++) begin : gStsReg
    for (genvar b = 0; b < REG_W; b++) begin : gStsBit
      if (b > 0 && (r * STS_PER + b - 1) < NUM_PINS) begin : gLive
        assign stsAsFlat[r*REG_W+b] = stsAsQ[r*STS_PER+b-1];
        assign stsDeFlat[r*REG_W+b] = stsDeQ[r*STS_PER+b-1];
      end else begin : gDead
        assign stsAsFlat[r*REG_W+b] = 1'b0;
        assign stsDeFlat[r*REG_W+b] = 1'b0;
      end
    end
  end

  for (genvar r = 0; r < CFG_REGS; r++) begin : gCfgReg
    for (genvar b = 0; b < REG_W; b++) begin : gCfgBit
      if ((r * CFG_PER + b) < NUM_PINS) begin : gLive
        assign polFlat[r*REG_W+b] = polQ[r*CFG_PER+b];
        assign enFlat[r*REG_W+b]  = enQ[r*CFG_PER+b];
      end else begin : gDead
        assign polFlat[r*REG_W+b] = 1'b0;
        assign enFlat[r*REG_W+b]  = 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strobe.rdKind)
      KIND_POL:    if (int'(strobe.rdIdx) < CFG_REGS) rdData = polFlat[int'(strobe.rdIdx)*REG_W +: REG_W];
      KIND_EN:     if (int'(strobe.rdIdx) < CFG_REGS) rdData = enFlat[int'(strobe.rdIdx)*REG_W +: REG_W];
      KIND_STS_AS: if (int'(strobe.rdIdx) < STS_REGS) rdData = stsAsFlat[int'(strobe.rdIdx)*REG_W +: REG_W];
      KIND_STS_DE: if (int'(strobe.rdIdx) < STS_REGS) rdData = stsDeFlat[int'(strobe.rdIdx)*REG_W +: REG_W];
      default:     rdData = '0;
    endcase
  end

  assign irqAssert   = |(stsAsQ & enQ);
  assign irqDeassert = |(stsDeQ & enQ);

endmodule

// File: rtl/gpio_evt_top.sv
module gpio_evt_top
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinsIn,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [REG_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [REG_W-1:0]    rdData,
  output logic                irqAssert,
  output logic                irqDeassert
);

  localparam int STS_BITS = ((NUM_PINS + STS_PER - 1) / STS_PER) * REG_W;

  ctrlStrobe_t         strobe;
  logic [NUM_PINS-1:0] evtAs, evtDe;
  logic [STS_BITS-1:0] stsAsFlat, stsDeFlat;

  gpio_evt_ctrl uCtrl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .strobe(strobe)
  );

  gpio_evt_datapath #(.NUM_PINS(NUM_PINS)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .pinsIn     (pinsIn),
    .strobe     (strobe),
    .rdData     (rdData),
    .irqAssert  (irqAssert),
    .irqDeassert(irqDeassert),
    .evtAs      (evtAs),
    .evtDe      (evtDe),
    .stsAsFlat  (stsAsFlat),
    .stsDeFlat  (stsDeFlat)
  );

endmodule

// File: rtl/gpio_evt_checker.sv
module gpio_evt_checker
  import gpio_evt_pkg::*;
#(
  parameter int NUM_PINS = 40,
  parameter int STS_BITS = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic [REG_W-1:0]    wrData,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic [REG_W-1:0]    rdData,
  input logic                irqAssert,
  input logic                irqDeassert,
  input logic [NUM_PINS-1:0] evtAs,
  input logic [NUM_PINS-1:0] evtDe,
  input logic [STS_BITS-1:0] stsAsFlat,
  input logic [STS_BITS-1:0] stsDeFlat
);

  logic wrAsReg0, wrDeReg0, rdSts;

  assign wrAsReg0 = wrEn && (wrAddr[ADDR_W-1 -: KIND_W] == 2'd2) && (wrAddr[REG_IDX_W-1:0] == '0);
  assign wrDeReg0 = wrEn && (wrAddr[ADDR_W-1 -: KIND_W] == 2'd3) && (wrAddr[REG_IDX_W-1:0] == '0);
  assign rdSts    = rdAddr[ADDR_W-1];

  // R1: quiet outputs and empty status while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |-> (!irqAssert && !irqDeassert && stsAsFlat == '0 && stsDeFlat == '0));

  // R9: an event on pin 0 is latched one edge later in both banks, even against a clear
  a_r9_assert_evt_latches: assert property (@(posedge clk) disable iff (!rstN)
    evtAs[0] |=> stsAsFlat[1]);
  a_r9_deassert_evt_latches: assert property (@(posedge clk) disable iff (!rstN)
    evtDe[0] |=> stsDeFlat[1]);

  // R7: set-mode write to pin 0 of the assert bank
  a_r7_set_pin0: assert property (@(posedge clk) disable iff (!rstN)
    (wrAsReg0 && wrData[0] && wrData[1]) |=> stsAsFlat[1]);

  // R6: clear-mode write to pin 0 of the deassert bank with no competing event
  a_r6_clear_pin0: assert property (@(posedge clk) disable iff (!rstN)
    (wrDeReg0 && !wrData[0] && wrData[1] && !evtDe[0]) |=> !stsDeFlat[1]);

  // R2: one edge of a pin never counts as both assert and deassert
  a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evtAs[0], evtDe[0]}));

  // R8: the assert interrupt only drops after a register write
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqAssert && !wrEn) |=> irqAssert);

  // R4: bit 0 of any status read is zero
  a_r4_bit0_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdSts |-> !rdData[0]);

endmodule

bind gpio_evt_top gpio_evt_checker #(
  .NUM_PINS(NUM_PINS),
  .STS_BITS(STS_BITS)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .rdAddr     (rdAddr),
  .rdData     (rdData),
  .irqAssert  (irqAssert),
  .irqDeassert(irqDeassert),
  .evtAs      (evtAs),
  .evtDe      (evtDe),
  .stsAsFlat  (stsAsFlat),
  .stsDeFlat  (stsDeFlat)
);

// File: tb/sim_gpio_evt_top.sv
module sim_gpio_evt_top;

  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NP-1:0] pinsIn;
  logic          wrEn;
  logic [4:0]    wrAddr;
  logic [31:0]   wrData;
  logic [4:0]    rdAddr;
  logic [31:0]   rdData;
  logic          irqAssert, irqDeassert;

  int nChecks = 0;
  int nFails  = 0;

  bit [NP-1:0] mPol, mEn, mSa, mSd;
  bit [NP-1:0] curPins;

  always #5 clk = ~clk;

  gpio_evt_top #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rstN(rstN), .pinsIn(pinsIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .irqAssert(irqAssert), .irqDeassert(irqDeassert)
  );

  function automatic logic [31:0] expReg(int kind, int idx);
    logic [31:0] v;
    v = '0;
    for (int p = 0; p < NP; p++) begin
      if (kind < 2) begin
        if (p / 32 == idx) v[p % 32] = (kind == 0) ? mPol[p] : mEn[p];
      end else begin
        if (p / 31 == idx) v[p % 31 + 1] = (kind == 2) ? mSa[p] : mSd[p];
      end
    end
    return v;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readReg(int kind, int idx, output logic [31:0] v);
    rdAddr = 5'((kind << 3) | idx);
    #1;
    v = rdData;
  endtask

  task automatic checkAll(string ctx);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 3; i++) begin
        readReg(k, i, v);
        chk(v, expReg(k, i), (k < 2) ? {"R5 cfg ", ctx} : {"R4 status ", ctx});
      end
    end
    chk(32'(irqAssert), 32'(|(mSa & mEn)), {"R8 irqAssert ", ctx});
    chk(32'(irqDeassert), 32'(|(mSd & mEn)), {"R8 irqDeassert ", ctx});
  endtask

  task automatic doWrite(int kind, int idx, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'((kind << 3) | idx); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (kind == 0 && p / 32 == idx) mPol[p] = d[p % 32];
      if (kind == 1 && p / 32 == idx) mEn[p]  = d[p % 32];
      if (kind == 2 && p / 31 == idx && d[p % 31 + 1]) mSa[p] = d[0];
      if (kind == 3 && p / 31 == idx && d[p % 31 + 1]) mSd[p] = d[0];
    end
  endtask

  task automatic drivePins(bit [NP-1:0] nv);
    bit [NP-1:0] r, f;
    @(negedge clk);
    r = nv & ~curPins;
    f = ~nv & curPins;
    pinsIn = nv;
    curPins = nv;
    repeat (3) @(negedge clk);
    mSa |= (r & mPol) | (f & ~mPol);
    mSd |= (f & mPol) | (r & ~mPol);
  endtask

  task automatic clearAllStatus();
    doWrite(2, 0, 32'hFFFF_FFFE); doWrite(2, 1, 32'hFFFF_FFFE);
    doWrite(3, 0, 32'hFFFF_FFFE); doWrite(3, 1, 32'hFFFF_FFFE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit [NP-1:0] nv;
    void'($urandom(32'd4711));
    rstN = 1'b0; pinsIn = '0; curPins = '0;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    mPol = '0; mEn = '0; mSa = '0; mSd = '0;
    repeat (3) @(negedge clk);
    chk(32'(irqAssert | irqDeassert), 32'h0, "R1 irq low in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after reset");

    // R5: configuration layout and readback, including the partial register
    doWrite(0, 0, 32'hFFFF_FFFF);
    doWrite(0, 1, 32'hFFFF_FFFF);
    readReg(0, 1, v); chk(v, 32'h0000_00FF, "R5 pol reg1 only pins 32..39");
    checkAll("R5 pol written");

    // R2: polarity 1 on pin 3
    nv = curPins; nv[3] = 1'b1; drivePins(nv);
    readReg(2, 0, v); chk(32'(v[4]), 32'h1, "R2 rise sets assert bank");
    readReg(3, 0, v); chk(32'(v[4]), 32'h0, "R2 rise leaves deassert bank");
    nv[3] = 1'b0; drivePins(nv);
    readReg(3, 0, v); chk(32'(v[4]), 32'h1, "R2 fall sets deassert bank");

    // R3: polarity 0 on pin 5
    doWrite(0, 0, 32'hFFFF_FFDF);
    nv[5] = 1'b1; drivePins(nv);
    readReg(3, 0, v); chk(32'(v[6]), 32'h1, "R3 rise sets deassert bank");
    readReg(2, 0, v); chk(32'(v[6]), 32'h0, "R3 rise leaves assert bank");
    nv[5] = 1'b0; drivePins(nv);
    readReg(2, 0, v); chk(32'(v[6]), 32'h1, "R3 fall sets assert bank");

    // R8: latched without enable, interrupt only after enabling
    chk(32'(irqAssert), 32'h0, "R8 no irq while disabled");
    doWrite(1, 0, 32'h0000_0008);
    chk(32'(irqAssert), 32'h1, "R8 irq after enable");
    checkAll("R8 enable");

    // R6: clear pin 3 only in the assert bank
    doWrite(2, 0, 32'h0000_0010);
    readReg(2, 0, v); chk(v, 32'h0000_0040, "R6 clear keeps pin 5");
    chk(32'(irqAssert), 32'h0, "R8 irq drops after clear");

    // R7: set pin 35 (index 1, bit 5) in the deassert bank
    doWrite(3, 1, 32'h0000_0021);
    readReg(3, 1, v); chk(v, 32'h0000_0020, "R7 set pin 35");
    checkAll("R7");

    // R10: latency of three rising edges
    clearAllStatus();
    @(negedge clk);
    pinsIn[0] = 1'b1; curPins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    readReg(2, 0, v); chk(32'(v[1]), 32'h0, "R10 not yet after two edges");
    @(negedge clk);
    readReg(2, 0, v); chk(32'(v[1]), 32'h1, "R10 set after three edges");
    mSa[0] = 1'b1;

    // R9: event in the same cycle as a clear of the same bit
    doWrite(2, 0, 32'h0000_0002);
    nv = curPins; nv[0] = 1'b0; drivePins(nv);
    @(negedge clk);
    pinsIn[0] = 1'b1; curPins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'h10; wrData = 32'h0000_0002;
    @(negedge clk);
    wrEn = 1'b0;
    readReg(2, 0, v); chk(32'(v[1]), 32'h1, "R9 event beats clear");
    mSa[0] = 1'b1;
    checkAll("R9");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: doWrite(0, int'($urandom_range(0, 2)), $urandom());
        1: doWrite(1, int'($urandom_range(0, 2)), $urandom());
        2: doWrite(int'($urandom_range(2, 3)), int'($urandom_range(0, 2)), $urandom());
        default: begin
          nv = curPins ^ NP'({$urandom(), $urandom()});
          drivePins(nv);
        end
      endcase
      checkAll("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule